// File: doc/BRIEF.md
# Spectrum Accumulation Sequencer with Host Counters

This block sits between the periodic sync heartbeat of a spectrometer pipeline and its vector accumulators. It counts sync strobes, one per spectrum, against a length that software programs. Every time that many spectra have gone by, it emits a single-cycle pulse that tells the accumulators to close the running accumulation and start a new one. The sync strobe is never passed straight through as this pulse.

For the host it keeps two wrapping counters. One counts every sync strobe, so software can check uptime and confirm that the pipeline is clocked. The other counts accumulation boundaries. A rising edge on a clear request zeroes both counters. Three indicator outputs drive LEDs: one for sync strobes, one for accumulation boundaries and one for clip events. Each indicator is held high for a fixed number of cycles so that single-cycle events can be seen.

Top module: `spec_acc_ctrl`

## Requirements
- R1: While reset is asserted and after its release, before any other stimulus, `newAccOut`, both counters and all three LEDs are 0.
- R2: The first `syncIn` strobe after reset produces a `newAccOut` pulse. Every pulse is exactly one cycle long and appears in the cycle after the clock edge that samples the strobe.
- R3: After each pulse, the next pulse comes on the L-th further `syncIn` strobe, where L is the accumulation length in force.
- R4: The length in force is the value of `accLenCfg` sampled on the strobe that produced the previous pulse. A change between boundaries has no effect until the next boundary.
- R5: An `accLenCfg` value of 0 behaves as a length of 1.
- R6: `syncCount` increases by one for every `syncIn` strobe. The new value is visible two cycles after the sampling edge.
- R7: `accCount` increases by one for every `newAccOut` pulse.
- R8: A 0-to-1 transition of `cntClrReq` zeroes both counters two cycles later. While the request stays high the counters count normally. The accumulation phase is not affected.
- R9: When a clear and a count increment fall on the same cycle, the clear wins and the counter reads 0.
- R10: Both counters are `CNT_W` bits wide and wrap from all ones to 0.
- R11: `ledSync` and `ledAcc` go high two cycles after a `syncIn` strobe or one cycle after a `newAccOut` pulse, respectively. Each stays high for exactly `LED_HOLD` cycles, and a new trigger restarts the hold.
- R12: `ledClip` goes high two cycles after a `clipIn` pulse and stays high for `LED_HOLD` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| syncIn | input | 1 | One-cycle strobe per spectrum |
| accLenCfg | input | CNT_W | Spectra per accumulation (0 acts as 1) |
| cntClrReq | input | 1 | Counter clear request, acts on its rising edge |
| clipIn | input | 1 | Clip event indicator |
| newAccOut | output | 1 | One-cycle accumulation boundary pulse |
| syncCount | output | CNT_W | Count of sync strobes |
| accCount | output | CNT_W | Count of accumulation boundaries |
| ledSync | output | 1 | Stretched sync indicator |
| ledAcc | output | 1 | Stretched boundary indicator |
| ledClip | output | 1 | Stretched clip indicator |

## Verification
The bench builds the block with `CNT_W` = 8 and `LED_HOLD` = 5. An 8-bit sync counter wraps after 256 strobes, which brings the wrap of R10 within a few hundred cycles. A five-cycle hold lets the exact first and last lit cycles of each indicator be checked directly. The stimulus table changes the length between boundaries, including to 0, so the deferred take-over of a new length can be followed across rows.

// File: rtl/spec_acc_pkg.sv
package spec_acc_pkg;
  // strobes handed from the sequencer to the counter datapath
  typedef struct packed {
    logic syncTick;
    logic accTick;
    logic clrTick;
    logic clipTick;
  } acc_strobe_t;

  localparam int LED_COUNT = 3;
  localparam int LED_SYNC  = 0;
  localparam int LED_ACC   = 1;
  localparam int LED_CLIP  = 2;
endpackage

// File: rtl/spec_acc_seq.sv
module spec_acc_seq
  import spec_acc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             syncIn,
  input  logic [CNT_W-1:0] accLenCfg,
  input  logic             cntClrReq,
  input  logic             clipIn,
  output acc_strobe_t      strobes
);
  logic [CNT_W-1:0] spectrumIdx;
  logic [CNT_W-1:0] activeLen;
  logic [CNT_W-1:0] nextLen;
  logic             clrPrev;
  logic             lastSpectrum;

  // a zero length is promoted to one spectrum per accumulation
  assign nextLen      = (accLenCfg == '0) ? CNT_W'(1) : accLenCfg;
  assign lastSpectrum = (spectrumIdx == activeLen - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      spectrumIdx <= '0;
      activeLen   <= CNT_W'(1);
      clrPrev     <= 1'b0;
      strobes     <= '0;
    end else begin
      clrPrev          <= cntClrReq;
      strobes.syncTick <= syncIn;
      strobes.clipTick <= clipIn;
      strobes.clrTick  <= cntClrReq & ~clrPrev;
      strobes.accTick  <= syncIn & lastSpectrum;
      if (syncIn) begin
        if (lastSpectrum) begin
          spectrumIdx <= '0;
          activeLen   <= nextLen;
        end else begin
          spectrumIdx <= spectrumIdx + CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/spec_acc_dp.sv
module spec_acc_dp
  import spec_acc_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int LED_HOLD = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  acc_strobe_t          strobes,
  output logic [CNT_W-1:0]     syncCount,
  output logic [CNT_W-1:0]     accCount,
  output logic [LED_COUNT-1:0] ledVec
);
  localparam int HOLD_W = $clog2(LED_HOLD + 1);

  logic [LED_COUNT-1:0] ledTrig;

  always_comb begin
    ledTrig           = '0;
    ledTrig[LED_SYNC] = strobes.syncTick;
    ledTrig[LED_ACC]  = strobes.accTick;
    ledTrig[LED_CLIP] = strobes.clipTick;
  end

  // host counters: clear has priority over increment, natural wrap
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncCount <= '0;
      accCount  <= '0;
    end else if (strobes.clrTick) begin
      syncCount <= '0;
      accCount  <= '0;
    end else begin
      if (strobes.syncTick) syncCount <= syncCount + CNT_W'(1);
      if (strobes.accTick)  accCount  <= accCount + CNT_W'(1);
    end
  end

  // one hold timer per indicator, reloaded on every trigger
  for (genvar g = 0; g < LED_COUNT; g++) begin : g_led
    logic [HOLD_W-1:0] holdLeft;
    always_ff @(posedge clk) begin
      if (!rstN)              holdLeft <= '0;
      else if (ledTrig[g])    holdLeft <= HOLD_W'(LED_HOLD);
      else if (holdLeft != 0) holdLeft <= holdLeft - HOLD_W'(1);
    end
    assign ledVec[g] = (holdLeft != '0);
  end
endmodule

// File: rtl/spec_acc_ctrl.sv
module spec_acc_ctrl
  import spec_acc_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int LED_HOLD = 16777216
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             syncIn,
  input  logic [CNT_W-1:0] accLenCfg,
  input  logic             cntClrReq,
  input  logic             clipIn,
  output logic             newAccOut,
  output logic [CNT_W-1:0] syncCount,
  output logic [CNT_W-1:0] accCount,
  output logic             ledSync,
  output logic             ledAcc,
  output logic             ledClip
);
  acc_strobe_t          strobes;
  logic [LED_COUNT-1:0] ledVec;

  spec_acc_seq #(.CNT_W(CNT_W)) u_seq (
    .clk       (clk),
    .rstN      (rstN),
    .syncIn    (syncIn),
    .accLenCfg (accLenCfg),
    .cntClrReq (cntClrReq),
    .clipIn    (clipIn),
    .strobes   (strobes)
  );

  spec_acc_dp #(.CNT_W(CNT_W), .LED_HOLD(LED_HOLD)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .syncCount (syncCount),
    .accCount  (accCount),
    .ledVec    (ledVec)
  );

  assign newAccOut = strobes.accTick;
  assign ledSync   = ledVec[LED_SYNC];
  assign ledAcc    = ledVec[LED_ACC];
  assign ledClip   = ledVec[LED_CLIP];
endmodule

// File: rtl/spec_acc_ctrl_chk.sv
module spec_acc_ctrl_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             syncIn,
  input logic             cntClrReq,
  input logic             clipIn,
  input logic             newAccOut,
  input logic [CNT_W-1:0] syncCount,
  input logic [CNT_W-1:0] accCount,
  input logic             ledSync,
  input logic             ledAcc,
  input logic             ledClip
);
  // R2: a boundary pulse only ever follows a sampled sync strobe
  p_pulse_after_sync_r2: assert property (@(posedge clk) disable iff (!rstN)
    newAccOut |-> $past(syncIn));

  // R6, R10: sync counter holds, steps by one (wrapping) or clears
  p_sync_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (syncCount == $past(syncCount)) ||
             (syncCount == $past(syncCount) + CNT_W'(1)) || (syncCount == '0));

  // R7: accumulation counter moves only after a boundary pulse or a clear
  p_acc_only_on_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    !newAccOut |=> (accCount == $past(accCount)) || (accCount == '0));

  // R8: rising clear request zeroes both counters two edges later
  p_clear_edge_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cntClrReq) |=> ##1 ((syncCount == '0) && (accCount == '0)));

  // R11: indicators light after their triggers
  p_led_sync_r11: assert property (@(posedge clk) disable iff (!rstN)
    syncIn |=> ##1 ledSync);
  p_led_acc_r11: assert property (@(posedge clk) disable iff (!rstN)
    newAccOut |=> ledAcc);

  // R12: clip indicator lights after a clip event
  p_led_clip_r12: assert property (@(posedge clk) disable iff (!rstN)
    clipIn |=> ##1 ledClip);
endmodule

bind spec_acc_ctrl spec_acc_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .syncIn    (syncIn),
  .cntClrReq (cntClrReq),
  .clipIn    (clipIn),
  .newAccOut (newAccOut),
  .syncCount (syncCount),
  .accCount  (accCount),
  .ledSync   (ledSync),
  .ledAcc    (ledAcc),
  .ledClip   (ledClip)
);

// File: tb/spec_acc_ctrl_bench.sv
module spec_acc_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 8;
  localparam int LED_HOLD   = 5;
  localparam int ROWS       = 5;
  // row fields: {length, syncs, pulses expected, syncCount after, accCount after}
  localparam logic [39:0] STIM [ROWS] = '{
    {8'd3, 8'd7, 8'd3, 8'd7,  8'd3},
    {8'd0, 8'd4, 8'd2, 8'd11, 8'd5},
    {8'd2, 8'd5, 8'd3, 8'd16, 8'd8},
    {8'd1, 8'd3, 8'd2, 8'd19, 8'd10},
    {8'd5, 8'd6, 8'd2, 8'd25, 8'd12}
  };

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             syncIn = 1'b0;
  logic [CNT_W-1:0] accLenCfg = '0;
  logic             cntClrReq = 1'b0;
  logic             clipIn = 1'b0;
  logic             newAccOut;
  logic [CNT_W-1:0] syncCount;
  logic [CNT_W-1:0] accCount;
  logic             ledSync, ledAcc, ledClip;

  int tests = 0;
  int fails = 0;
  int pulseSeen = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spec_acc_ctrl #(.CNT_W(CNT_W), .LED_HOLD(LED_HOLD)) u_spec_acc_ctrl (
    .clk(clk), .rstN(rstN), .syncIn(syncIn), .accLenCfg(accLenCfg),
    .cntClrReq(cntClrReq), .clipIn(clipIn), .newAccOut(newAccOut),
    .syncCount(syncCount), .accCount(accCount),
    .ledSync(ledSync), .ledAcc(ledAcc), .ledClip(ledClip)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one strobe, pulse sampled in the following cycle, one idle cycle
  task automatic sendSync();
    @(negedge clk) syncIn = 1'b1;
    @(negedge clk) syncIn = 1'b0;
    if (newAccOut) pulseSeen++;
    @(negedge clk);
    if (newAccOut) check(1'b0, "R2 pulse width", 1, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check({newAccOut, syncCount, accCount, ledSync, ledAcc, ledClip} == '0,
          "R1 in reset", int'(syncCount), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check({newAccOut, syncCount, accCount, ledSync, ledAcc, ledClip} == '0,
          "R1 after release", int'(accCount), 0);

    // R2 R3 R4 R5 R6 R7: table walk
    for (int r = 0; r < ROWS; r++) begin
      accLenCfg = STIM[r][39:32];
      pulseSeen = 0;
      for (int s = 0; s < int'(STIM[r][31:24]); s++) sendSync();
      check(pulseSeen == int'(STIM[r][23:16]), "R3 R4 R5 pulses in row",
            pulseSeen, int'(STIM[r][23:16]));
      check(syncCount == STIM[r][15:8], "R6 sync count", int'(syncCount), int'(STIM[r][15:8]));
      check(accCount == STIM[r][7:0], "R7 acc count", int'(accCount), int'(STIM[r][7:0]));
    end

    // R8: rising edge clears, held level does not block counting
    @(negedge clk) cntClrReq = 1'b1;
    repeat (2) @(negedge clk);
    check(syncCount == 0 && accCount == 0, "R8 clear", int'(syncCount), 0);
    sendSync();
    sendSync();
    check(syncCount == 2, "R8 count while held", int'(syncCount), 2);
    check(accCount == 0, "R8 acc while held", int'(accCount), 0);

    // R9: clear and increment in the same cycle
    @(negedge clk) cntClrReq = 1'b0;
    @(negedge clk) begin cntClrReq = 1'b1; syncIn = 1'b1; end
    @(negedge clk) syncIn = 1'b0;
    repeat (2) @(negedge clk);
    check(syncCount == 0, "R9 clear wins", int'(syncCount), 0);

    // R10: wrap of the 8-bit sync counter
    pulseSeen = 0;
    for (int s = 0; s < 255; s++) sendSync();
    check(syncCount == 255, "R10 before wrap", int'(syncCount), 255);
    sendSync();
    check(syncCount == 0, "R10 wrap", int'(syncCount), 0);
    check(accCount == 51, "R3 acc over wrap run", int'(accCount), 51);

    // R11: stretch window of sync and boundary indicators
    repeat (12) @(negedge clk);
    check(!ledSync && !ledAcc, "R11 idle dark", int'(ledSync), 0);
    @(negedge clk) syncIn = 1'b1;
    @(negedge clk) syncIn = 1'b0;
    check(newAccOut == 1'b1, "R3 boundary on fifth", int'(newAccOut), 1);
    @(negedge clk);
    check(ledSync && ledAcc, "R11 first lit", int'(ledSync), 1);
    repeat (4) @(negedge clk);
    check(ledSync && ledAcc, "R11 last lit", int'(ledAcc), 1);
    @(negedge clk);
    check(!ledSync && !ledAcc, "R11 dark after hold", int'(ledSync), 0);

    // R11: retrigger restarts the hold
    @(negedge clk) syncIn = 1'b1;
    @(negedge clk) syncIn = 1'b0;
    repeat (3) @(negedge clk) ;
    @(negedge clk) syncIn = 1'b1;
    @(negedge clk) syncIn = 1'b0;
    repeat (5) @(negedge clk);
    check(ledSync == 1'b1, "R11 retrigger extends", int'(ledSync), 1);
    @(negedge clk);
    check(ledSync == 1'b0, "R11 retrigger end", int'(ledSync), 0);

    // R12: clip indicator
    check(ledClip == 1'b0, "R12 clip dark", int'(ledClip), 0);
    @(negedge clk) clipIn = 1'b1;
    @(negedge clk) clipIn = 1'b0;
    @(negedge clk);
    check(ledClip == 1'b1, "R12 clip lit", int'(ledClip), 1);
    repeat (4) @(negedge clk);
    check(ledClip == 1'b1, "R12 clip last lit", int'(ledClip), 1);
    @(negedge clk);
    check(ledClip == 1'b0, "R12 clip dark after", int'(ledClip), 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule